// File: doc/BRIEF.md
# SPI Master with Programmable Select and Frame Spacing

This block is a mode-0 SPI master that moves a burst of data frames to a single slave while the select line stays asserted. The host loads a frame count and the timing settings and pulses a start. The block then asks for each transmit word with a ready/valid handshake and shifts it out MSB first. It returns every received word with a one-cycle strobe, and when the whole burst has finished it raises a done pulse.

Three idle intervals are programmed in whole SCK periods, and a value of zero removes the interval. The lead delay sits between the select going low and the first rising clock edge. The gap sits between two frames of the same burst while the select stays low. The hold delay sits between the last falling clock edge and the select returning high. In pulse mode the select is released after every frame, after the hold delay. It stays high for one SCK period plus the gap, then falls again and the lead delay is applied before the next frame. SCK comes from the system clock through a programmable half-period divider. Frames are 8 or 16 bits wide.

Top module: `spi_delay_master`

## Requirements
- R1: Out of reset, and whenever no burst is running, `ss_n` is 1 and `sck`, `busy`, `tx_ready` and `done` are 0.
- R2: A `start` pulse with a nonzero `word_count` captures the frame count and all timing settings, raises `busy` in the following cycle, and requests the first word with `tx_ready` while `ss_n` is still high. A `start` with `word_count` = 0, or any `start` while `busy` is 1, has no effect.
- R3: Within a frame, every high and every low phase of `sck` lasts `sck_half_div`+1 system clocks.
- R4: From the falling edge of `ss_n` to the next rising edge of `sck`, (2·`lead_cnt`+1)·(`sck_half_div`+1) clocks elapse. `sck` is never high while `ss_n` is high.
- R5: A frame carries 16 bits when `frame16` is 1 and 8 bits when it is 0. An 8-bit frame sends `tx_data[7:0]`. Bits go out MSB first. `mosi` changes only while `sck` is low, and the slave captures it on the rising edge.
- R6: `miso` is sampled on each rising edge of `sck`. At the last falling edge of a frame, `rx_valid` is 1 for exactly one clock, and `rx_data` then holds the received word. For 8-bit frames the word sits in bits 7:0 and bits 15:8 are 0.
- R7: With `ss_pulse` = 0, `ss_n` stays low from the first frame until after the last frame. If the next word is offered at once, (2·`gap_cnt`+1)·(`sck_half_div`+1)+1 clocks pass from the last falling `sck` edge of one frame to the first rising edge of the next, the +1 being the handshake cycle.
- R8: `ss_n` returns high 2·`hold_cnt`·(`sck_half_div`+1) clocks after the last falling `sck` edge of the frame that releases it.
- R9: With `ss_pulse` = 1, `ss_n` is released after every frame. If the next word is offered at once, it stays high for 2·(`gap_cnt`+1)·(`sck_half_div`+1)+1 clocks before falling, and the R4 lead timing then applies again.
- R10: `done` is 1 for exactly one clock, in the first cycle in which `ss_n` is high again after the last frame. `busy` is 0 in the next cycle.
- R11: `tx_ready` is 1 only while the block waits for a word. While the host withholds `tx_valid`, no frame starts, `sck` stays low and `tx_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a burst |
| word_count | input | CNT_W | Number of frames in the burst |
| sck_half_div | input | 8 | SCK half period in system clocks, minus one |
| frame16 | input | 1 | 1 selects 16-bit frames, 0 selects 8-bit frames |
| ss_pulse | input | 1 | Release the select after every frame |
| lead_cnt | input | 4 | Select-to-first-clock delay, in SCK periods |
| gap_cnt | input | 4 | Idle periods between frames |
| hold_cnt | input | 4 | Last-clock-to-release delay, in SCK periods |
| tx_data | input | 16 | Transmit word |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Block takes a transmit word |
| rx_data | output | 16 | Received word |
| rx_valid | output | 1 | One-clock strobe for `rx_data` |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-clock end-of-burst pulse |
| ss_n | output | 1 | Active-low slave select |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench measures every interval in system clocks. It covers zero settings for lead, gap and hold at a divider of one, where an off-by-one in the delay counters would move the first rising edge or the release of the select by whole half-periods. It mixes 8- and 16-bit frames against a slave model, which exposes a design that puts the narrow byte at the wrong end of the shifter or leaves stale upper bits in a received byte. Pulse-mode bursts would show a select that stays low, or a missing second lead delay. Stalled handshakes and a start issued in the middle of a burst would show a design that clocks without data or restarts with the new frame count.

// File: rtl/spi_dm_pkg.sv
package spi_dm_pkg;

    parameter int DIV_W     = 8;
    parameter int DLY_W     = 4;
    parameter int FRAME_MAX = 16;

    localparam int BIT_W  = $clog2(FRAME_MAX);
    localparam int TICK_W = DLY_W + 2;
    localparam int HALF_F = FRAME_MAX / 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LEAD,
        ST_SHIFT,
        ST_GAP,
        ST_HOLD,
        ST_SSOFF,
        ST_FIN
    } state_t;

    typedef struct packed {
        logic [DIV_W-1:0] half_div;
        logic             wide;
        logic             pulse;
        logic [DLY_W-1:0] lead;
        logic [DLY_W-1:0] gap;
        logic [DLY_W-1:0] hold;
    } cfg_t;

    // Number of divider ticks (half SCK periods) for a delay in whole periods,
    // optionally extended by one extra period.
    function automatic logic [TICK_W-1:0] half_ticks(input logic [DLY_W-1:0] periods,
                                                     input logic              extra);
        logic [TICK_W-1:0] base;
        base = TICK_W'({periods, 1'b0});
        return extra ? base + TICK_W'(2) : base;
    endfunction

    function automatic logic [BIT_W-1:0] last_bit(input logic wide);
        return wide ? BIT_W'(FRAME_MAX - 1) : BIT_W'(HALF_F - 1);
    endfunction

endpackage

// File: rtl/spi_dm_clkdiv.sv
module spi_dm_clkdiv
    import spi_dm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == half_div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spi_dm_shifter.sv
module spi_dm_shifter
    import spi_dm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [FRAME_MAX-1:0] load_word,
    input  logic                 wide,
    input  logic                 shift_out,
    input  logic                 sample,
    input  logic                 miso,
    output logic                 mosi,
    output logic [FRAME_MAX-1:0] rx_word
);

    logic [FRAME_MAX-1:0] tx_sh;
    logic [FRAME_MAX-1:0] rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh <= '0;
            rx_sh <= '0;
        end else if (load) begin
            tx_sh <= wide ? load_word : {load_word[HALF_F-1:0], {HALF_F{1'b0}}};
            rx_sh <= '0;
        end else begin
            if (shift_out) begin
                tx_sh <= {tx_sh[FRAME_MAX-2:0], 1'b0};
            end
            if (sample) begin
                rx_sh <= {rx_sh[FRAME_MAX-2:0], miso};
            end
        end
    end

    assign mosi    = tx_sh[FRAME_MAX-1];
    assign rx_word = wide ? rx_sh : {{HALF_F{1'b0}}, rx_sh[HALF_F-1:0]};

endmodule

// File: rtl/spi_delay_master.sv
module spi_delay_master
    import spi_dm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [CNT_W-1:0]     word_count,
    input  logic [DIV_W-1:0]     sck_half_div,
    input  logic                 frame16,
    input  logic                 ss_pulse,
    input  logic [DLY_W-1:0]     lead_cnt,
    input  logic [DLY_W-1:0]     gap_cnt,
    input  logic [DLY_W-1:0]     hold_cnt,
    input  logic [FRAME_MAX-1:0] tx_data,
    input  logic                 tx_valid,
    output logic                 tx_ready,
    output logic [FRAME_MAX-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 busy,
    output logic                 done,
    output logic                 ss_n,
    output logic                 sck,
    output logic                 mosi,
    input  logic                 miso
);

    state_t            state;
    cfg_t              cfg;
    logic [CNT_W-1:0]  frames_left;
    logic [BIT_W-1:0]  bit_idx;
    logic [TICK_W-1:0] dly;
    logic              ph;
    logic              tick;
    logic              run;
    logic              accept;
    logic [FRAME_MAX-1:0] rx_word;

    assign run      = (state == ST_LEAD) || (state == ST_SHIFT) || (state == ST_GAP) ||
                      (state == ST_HOLD) || (state == ST_SSOFF);
    assign accept   = (state == ST_FETCH) && tx_valid;
    assign tx_ready = (state == ST_FETCH);
    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_FIN);

    spi_dm_clkdiv u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .half_div (cfg.half_div),
        .tick     (tick)
    );

    spi_dm_shifter u_sh (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_word (tx_data),
        .wide      (cfg.wide),
        .shift_out ((state == ST_SHIFT) && tick && ph && (bit_idx != '0)),
        .sample    ((state == ST_SHIFT) && tick && !ph),
        .miso      (miso),
        .mosi      (mosi),
        .rx_word   (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cfg         <= '0;
            frames_left <= '0;
            bit_idx     <= '0;
            dly         <= '0;
            ph          <= 1'b0;
            ss_n        <= 1'b1;
            sck         <= 1'b0;
            rx_valid    <= 1'b0;
            rx_data     <= '0;
        end else begin
            rx_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start && (word_count != '0)) begin
                        cfg <= '{half_div: sck_half_div, wide: frame16, pulse: ss_pulse,
                                 lead: lead_cnt, gap: gap_cnt, hold: hold_cnt};
                        frames_left <= word_count;
                        state       <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (tx_valid) begin
                        ph      <= 1'b0;
                        bit_idx <= last_bit(cfg.wide);
                        if (ss_n) begin
                            ss_n <= 1'b0;
                            if (cfg.lead != '0) begin
                                dly   <= half_ticks(cfg.lead, 1'b0);
                                state <= ST_LEAD;
                            end else begin
                                state <= ST_SHIFT;
                            end
                        end else if (cfg.gap != '0) begin
                            dly   <= half_ticks(cfg.gap, 1'b0);
                            state <= ST_GAP;
                        end else begin
                            state <= ST_SHIFT;
                        end
                    end
                end
                ST_LEAD, ST_GAP: begin
                    if (tick) begin
                        if (dly == TICK_W'(1)) begin
                            state <= ST_SHIFT;
                        end
                        dly <= dly - 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!ph) begin
                            sck <= 1'b1;
                            ph  <= 1'b1;
                        end else begin
                            sck <= 1'b0;
                            ph  <= 1'b0;
                            if (bit_idx != '0) begin
                                bit_idx <= bit_idx - 1'b1;
                            end else begin
                                rx_valid    <= 1'b1;
                                rx_data     <= rx_word;
                                frames_left <= frames_left - 1'b1;
                                if ((frames_left == CNT_W'(1)) || cfg.pulse) begin
                                    if (cfg.hold != '0) begin
                                        dly   <= half_ticks(cfg.hold, 1'b0);
                                        state <= ST_HOLD;
                                    end else begin
                                        ss_n <= 1'b1;
                                        if (frames_left == CNT_W'(1)) begin
                                            state <= ST_FIN;
                                        end else begin
                                            dly   <= half_ticks(cfg.gap, 1'b1);
                                            state <= ST_SSOFF;
                                        end
                                    end
                                end else begin
                                    state <= ST_FETCH;
                                end
                            end
                        end
                    end
                end
                ST_HOLD: begin
                    if (tick) begin
                        if (dly == TICK_W'(1)) begin
                            ss_n <= 1'b1;
                            if (frames_left == '0) begin
                                state <= ST_FIN;
                            end else begin
                                dly   <= half_ticks(cfg.gap, 1'b1);
                                state <= ST_SSOFF;
                            end
                        end else begin
                            dly <= dly - 1'b1;
                        end
                    end
                end
                ST_SSOFF: begin
                    if (tick) begin
                        if (dly == TICK_W'(1)) begin
                            state <= ST_FETCH;
                        end
                        dly <= dly - 1'b1;
                    end
                end
                ST_FIN: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/spi_dm_checker.sv
module spi_dm_checker (
    input logic clk,
    input logic rst,
    input logic ss_n,
    input logic sck,
    input logic mosi,
    input logic busy,
    input logic done,
    input logic tx_ready,
    input logic rx_valid
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ss_n && !sck && !tx_ready)) else $error("idle outputs"); // R1

    AST_SCK_NEEDS_SS: assert property (@(posedge clk) disable iff (rst)
        ss_n |-> !sck) else $error("sck while deselected"); // R4

    AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(mosi)) else $error("mosi moved while sck high"); // R5

    AST_RX_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid) else $error("rx strobe longer than one clock"); // R6

    AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        done |-> (ss_n && !sck)) else $error("done while selected"); // R10

    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!busy && !done)) else $error("busy after done"); // R10

    AST_READY_CLOCK_LOW: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> (busy && !sck)) else $error("sck high while waiting for data"); // R11

endmodule

bind spi_delay_master spi_dm_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .ss_n     (ss_n),
    .sck      (sck),
    .mosi     (mosi),
    .busy     (busy),
    .done     (done),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid)
);

// File: tb/tb_spi_delay_master.sv
module tb_spi_delay_master;
    import spi_dm_pkg::*;

    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [CNT_W-1:0] word_count = '0;
    logic [DIV_W-1:0] sck_half_div = '0;
    logic frame16 = 1'b0;
    logic ss_pulse = 1'b0;
    logic [DLY_W-1:0] lead_cnt = '0;
    logic [DLY_W-1:0] gap_cnt = '0;
    logic [DLY_W-1:0] hold_cnt = '0;
    logic [15:0] tx_data = '0;
    logic tx_valid = 1'b0;
    logic tx_ready;
    logic [15:0] rx_data;
    logic rx_valid, busy, done, ss_n, sck, mosi;
    logic miso;

    spi_delay_master #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .start(start), .word_count(word_count),
        .sck_half_div(sck_half_div), .frame16(frame16), .ss_pulse(ss_pulse),
        .lead_cnt(lead_cnt), .gap_cnt(gap_cnt), .hold_cnt(hold_cnt),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy), .done(done),
        .ss_n(ss_n), .sck(sck), .mosi(mosi), .miso(miso)
    );

    always #2 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // Expected-behaviour settings of the burst in flight
    int c_h = 1, c_l = 0, c_g = 0, c_hd = 0, c_n = 0, wlen = 8;
    bit c_w = 0, c_p = 0, c_stall = 0;
    logic [15:0] tw [8];
    logic [15:0] sw [8];

    // Monitor state
    longint cyc = 0, t_ssfall = 0, t_ssrise = 0, t_lastfall = 0, t_edge = 0;
    int fi = 0, nb = 0;
    logic psck = 1'b0, pss = 1'b1, pmosi = 1'b0, pdone = 1'b0;
    logic [15:0] cap = '0;
    bit mosi_bad = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] fit(input logic [15:0] w, input bit wide);
        return wide ? w : {8'h00, w[7:0]};
    endfunction

    // Slave model: presents the next bit before each rising edge
    always_comb begin
        miso = 1'b0;
        if (fi < 8 && nb < wlen) miso = sw[fi][wlen-1-nb];
    end

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (!sck && psck) begin
                check(cyc - t_edge == c_h, "R3 high phase", cyc - t_edge, c_h);
                t_edge     = cyc;
                t_lastfall = cyc;
            end
            if (sck && !psck) begin
                if (nb == 0) begin
                    if (fi == 0 || c_p)
                        check(cyc - t_ssfall == (2*c_l+1)*c_h, "R4 lead", cyc - t_ssfall, (2*c_l+1)*c_h);
                    else if (!c_stall)
                        check(cyc - t_lastfall == (2*c_g+1)*c_h+1, "R7 gap", cyc - t_lastfall, (2*c_g+1)*c_h+1);
                end else begin
                    check(cyc - t_edge == c_h, "R3 low phase", cyc - t_edge, c_h);
                end
                cap = {cap[14:0], mosi};
                nb++;
                t_edge = cyc;
            end
            if (sck && psck && (mosi != pmosi)) mosi_bad = 1;
            if (rx_valid) begin
                check(cyc == t_lastfall && nb == wlen, "R6 strobe at last fall", nb, wlen);
                check(rx_data == fit(sw[fi], c_w), "R6 rx word", rx_data, fit(sw[fi], c_w));
                check(fit(cap, c_w) == fit(tw[fi], c_w), "R5 mosi word", fit(cap, c_w), fit(tw[fi], c_w));
                check(!mosi_bad, "R5 mosi stable while high", mosi_bad, 0);
                fi++;
                nb = 0;
                cap = '0;
                mosi_bad = 0;
            end
            if (ss_n && !pss) begin
                check(cyc - t_lastfall == 2*c_hd*c_h, "R8 hold", cyc - t_lastfall, 2*c_hd*c_h);
                if (!c_p) check(fi == c_n, "R7 select held", fi, c_n);
                t_ssrise = cyc;
            end
            if (!ss_n && pss) begin
                if (fi > 0 && !c_stall)
                    check(cyc - t_ssrise == 2*(c_g+1)*c_h+1, "R9 pulse high time",
                          cyc - t_ssrise, 2*(c_g+1)*c_h+1);
                t_ssfall = cyc;
            end
            if (pdone) check(!busy, "R10 busy after done", busy, 0);
            if (done) begin
                check(ss_n && fi == c_n, "R10 frames at done", fi, c_n);
                check(cyc == t_ssrise, "R10 done timing", cyc, t_ssrise);
                fi = 0;
            end
        end
        psck  = sck;
        pss   = ss_n;
        pmosi = mosi;
        pdone = done;
    end

    task automatic setup(input int hd, input int ld, input int gp, input int hl,
                         input bit wide, input bit pulse);
        sck_half_div = DIV_W'(hd);
        lead_cnt = DLY_W'(ld);
        gap_cnt  = DLY_W'(gp);
        hold_cnt = DLY_W'(hl);
        frame16  = wide;
        ss_pulse = pulse;
        c_h = hd + 1; c_l = ld; c_g = gp; c_hd = hl;
        c_w = wide; c_p = pulse; wlen = wide ? 16 : 8;
    endtask

    task automatic run_xfer(input int n, input bit stall);
        @(negedge clk);
        c_n = n;
        c_stall = stall;
        start = 1'b1;
        word_count = CNT_W'(n);
        @(negedge clk);
        start = 1'b0;
        check(busy && tx_ready && ss_n, "R2 start accepted", {busy, tx_ready, ss_n}, 3'b111);
        for (int i = 0; i < n; i++) begin
            if (stall) begin
                tx_valid = 1'b0;
                while (!tx_ready) @(negedge clk);
                repeat (5) @(negedge clk);
                check(tx_ready && !sck, "R11 waits for data", {tx_ready, sck}, 2'b10);
            end
            tx_data  = tw[i];
            tx_valid = 1'b1;
            while (!tx_ready) @(negedge clk);
            @(posedge clk);
            #1;
            tx_valid = 1'b0;
            if (i == 0) begin
                // R2: a start during the burst must be ignored
                start = 1'b1;
                word_count = CNT_W'(n + 2);
                @(posedge clk);
                #1;
                start = 1'b0;
            end
        end
        do @(negedge clk); while (!done);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ss_n && !sck && !busy && !tx_ready && !done, "R1 reset state",
              {ss_n, sck, busy, tx_ready, done}, 5'b10000);

        // R2: zero word count is ignored
        word_count = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        check(!busy && ss_n && !tx_ready, "R2 zero count ignored", busy, 0);

        // Directed: 8-bit held burst with lead 2, gap 2, hold 1
        setup(1, 2, 2, 1, 1'b0, 1'b0);
        tw[0] = 16'h00A5; tw[1] = 16'h005A; tw[2] = 16'h003C;
        sw[0] = 16'h00C3; sw[1] = 16'h0081; sw[2] = 16'h007E;
        run_xfer(3, 1'b0);

        // Directed: 16-bit, all delays zero, fastest clock
        setup(0, 0, 0, 0, 1'b1, 1'b0);
        tw[0] = 16'hBEEF; tw[1] = 16'h8001;
        sw[0] = 16'h1234; sw[1] = 16'hFFFE;
        run_xfer(2, 1'b0);

        // Directed: pulse mode, zero gap and hold
        setup(2, 1, 0, 0, 1'b0, 1'b1);
        tw[0] = 16'h0011; tw[1] = 16'h0022; tw[2] = 16'h0033;
        sw[0] = 16'h00F0; sw[1] = 16'h000F; sw[2] = 16'h0055;
        run_xfer(3, 1'b0);

        // Directed: stalled handshake in held mode
        setup(1, 1, 1, 2, 1'b1, 1'b0);
        tw[0] = 16'hA0A0; tw[1] = 16'h0B0B;
        sw[0] = 16'h5151; sw[1] = 16'hE7E7;
        run_xfer(2, 1'b1);

        // Constrained random bursts
        for (int k = 0; k < 24; k++) begin
            int nfr;
            setup(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                  int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            nfr = int'($urandom_range(1, 4));
            for (int j = 0; j < 8; j++) begin
                tw[j] = 16'($urandom);
                sw[j] = 16'($urandom);
            end
            run_xfer(nfr, ($urandom_range(0, 3) == 0));
        end

        repeat (4) @(negedge clk);
        check(ss_n && !sck && !busy && !tx_ready && !done, "R1 idle after bursts",
              {ss_n, sck, busy, tx_ready, done}, 5'b10000);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule